// File: doc/BRIEF.md
# Decimal Add/Subtract Unit

This block adds or subtracts two packed-BCD operands of `DIGITS` decimal digits. It has no clock and settles in a single combinational pass. The decimal adjustment sits around one plain binary ripple adder.

Before the adder, each digit of B is adjusted according to the operation:

- **Addition:** each B digit is biased upward by six.
- **Subtraction:** each B digit is inverted bit-wise (fifteen minus the digit). This gives the nine's complement once the bias is taken into account.

After the adder, each digit is corrected by looking only at the binary carry leaving that digit:

- **Carry present:** the digit keeps its four adder bits unchanged.
- **No carry:** six is subtracted from the digit, modulo sixteen. Nothing is borrowed from the digit above.

The carry out of the top digit is the decimal carry for addition and the no-borrow flag for subtraction. A datapath places the block between operand registers and uses `cout` to chain wider operations or to set a condition flag.

Top module: `bcd_addsub`

## Requirements
- R1: With `sub`=0 and all digits of `a` and `b` in 0..9, `result` equals (A + B + `cin`) mod 10^DIGITS, where A and B are the decimal values of the operands and digit i occupies bits [4i+3:4i], least significant digit in bits [3:0].
- R2: With `sub`=0 and valid digits, `cout` is 1 exactly when A + B + `cin` is at least 10^DIGITS.
- R3: With `sub`=1 and valid digits, `result` equals (A - B) mod 10^DIGITS, the ten's complement when B exceeds A.
- R4: With `sub`=1 and valid digits, `cout` is 1 exactly when A is greater than or equal to B (no borrow).
- R5: In addition mode, `cin`=1 adds exactly one unit to the least significant digit, and any resulting carry propagates through all higher digits.
- R6: In subtraction mode, `cin` has no effect on `result` or `cout`.
- R7: For valid input digits, every digit of `result` lies in 0..9 in both modes.
- R8: A carry or borrow ripples across the whole operand width: in addition, 99..9 + 00..1 gives 00..0 with `cout`=1; in subtraction, 00..0 - 00..1 gives 99..9 with `cout`=0.
- R9: Subtracting an operand from itself yields zero with `cout`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4*DIGITS | Packed-BCD first operand (minuend in subtraction) |
| b | input | 4*DIGITS | Packed-BCD second operand (subtrahend in subtraction) |
| sub | input | 1 | 0 selects addition, 1 selects subtraction |
| cin | input | 1 | Carry-in for addition; ignored in subtraction |
| result | output | 4*DIGITS | Packed-BCD sum or difference |
| cout | output | 1 | Decimal carry (addition) or no-borrow (subtraction) |

## Verification
The block holds no state. Any internal fault therefore shows at the ports in the same evaluation that applies the triggering operands.

The likely faults each leave a visible mark:

- A wrong bias or complement on B shifts every digit away from its decimal value.
- A correction keyed to the wrong carry produces either a non-decimal digit (10..15) or an error of six in one digit.
- A carry chain broken between digits shows up only in operands where a carry crosses that boundary.

For these reasons the bench sweeps every two-digit operand pair in both modes with both carry-in values, then runs random and fully rippling four-digit operands.

// File: rtl/bcd_addsub.sv
module bcd_addsub #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  input  logic                sub,
  input  logic                cin,
  output logic [4*DIGITS-1:0] result,
  output logic                cout
);
  localparam int W = 4 * DIGITS;

  logic       chain;
  logic [3:0] bmod;
  logic [4:0] dsum;

  function automatic logic is_bcd(input logic [W-1:0] v);
    for (int k = 0; k < DIGITS; k++)
      if (v[4*k +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  always_comb begin
    chain  = sub ? 1'b1 : cin;
    result = '0;
    bmod   = '0;
    dsum   = '0;
    for (int i = 0; i < DIGITS; i++) begin
      bmod  = sub ? ~b[4*i +: 4] : b[4*i +: 4] + 4'd6;
      dsum  = {1'b0, a[4*i +: 4]} + {1'b0, bmod} + {4'b0, chain};
      chain = dsum[4];
      result[4*i +: 4] = chain ? dsum[3:0] : dsum[3:0] - 4'd6;
    end
    cout = chain;

    if (is_bcd(a) && is_bcd(b)) begin
      // R7
      digit_range_chk: assert (is_bcd(result));
      // R4
      if (sub) begin
        no_borrow_chk: assert (cout == (a >= b));
      end
      // R2
      if (!sub && !cout) begin
        add_grow_chk: assert (result >= a);
      end
    end
    // R9
    if (sub && a == b && is_bcd(a)) begin
      self_sub_chk: assert (result == '0 && cout);
    end
    // R5
    if (!sub && a == '0 && b == '0) begin
      cin_only_chk: assert (result == W'(cin) && !cout);
    end
  end
endmodule

// File: tb/bcd_addsub_tb.sv
module bcd_addsub_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [7:0]  a2, b2, r2;
  logic        s2, c2, o2;
  logic [15:0] a4, b4, r4;
  logic        s4, c4, o4;

  bcd_addsub #(.DIGITS(2)) u_dut  (.a(a2), .b(b2), .sub(s2), .cin(c2), .result(r2), .cout(o2));
  bcd_addsub #(.DIGITS(4)) u_wide (.a(a4), .b(b4), .sub(s4), .cin(c4), .result(r4), .cout(o4));

  function automatic int bcd2int(input logic [15:0] v, input int nd);
    int x = 0;
    for (int k = nd - 1; k >= 0; k--) x = x * 10 + int'(v[4*k +: 4]);
    return x;
  endfunction

  function automatic logic [15:0] int2bcd(input int x, input int nd);
    logic [15:0] v = '0;
    int y = x;
    for (int k = 0; k < nd; k++) begin
      v[4*k +: 4] = 4'(y % 10);
      y = y / 10;
    end
    return v;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model(input int ia, input int ib, input logic sb, input logic ci, input int nd,
                       output int er, output int ec);
    int m = 1;
    for (int k = 0; k < nd; k++) m = m * 10;
    if (!sb) begin
      er = (ia + ib + int'(ci)) % m;
      ec = (ia + ib + int'(ci)) >= m ? 1 : 0;
    end else begin
      er = (ia - ib + m) % m;
      ec = ia >= ib ? 1 : 0;
    end
  endtask

  task automatic run2(input int ia, input int ib, input logic sb, input logic ci);
    int er, ec;
    @(negedge clk);
    a2 = int2bcd(ia, 2)[7:0]; b2 = int2bcd(ib, 2)[7:0]; s2 = sb; c2 = ci;
    #2;
    model(ia, ib, sb, ci, 2, er, ec);
    if (!sb) begin
      check("R1,R5 add result", bcd2int({8'h0, r2}, 2), er);
      check("R2 add carry", int'(o2), ec);
    end else begin
      check(ci ? "R3 sub result" : "R3,R6 sub result cin=0", bcd2int({8'h0, r2}, 2), er);
      check(ia == ib ? "R4,R9 sub no-borrow" : "R4,R6 sub no-borrow", int'(o2), ec);
    end
    check("R7 digit range", int'(r2[7:4] <= 4'd9 && r2[3:0] <= 4'd9), 1);
  endtask

  task automatic run4(input logic [15:0] va, input logic [15:0] vb, input logic sb, input logic ci,
                      input string tag);
    int er, ec;
    @(negedge clk);
    a4 = va; b4 = vb; s4 = sb; c4 = ci;
    #2;
    model(bcd2int(va, 4), bcd2int(vb, 4), sb, ci, 4, er, ec);
    check({tag, " result"}, int'(r4), int'(int2bcd(er, 4)));
    check({tag, " carry"}, int'(o4), ec);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    a2 = '0; b2 = '0; s2 = 1'b0; c2 = 1'b0;
    a4 = '0; b4 = '0; s4 = 1'b0; c4 = 1'b0;
    #2;
    check("R1 idle zero result", int'(r4), 0);
    check("R2 idle zero carry", int'(o4), 0);

    for (int ia = 0; ia < 100; ia++)
      for (int ib = 0; ib < 100; ib++)
        for (int m = 0; m < 4; m++)
          run2(ia, ib, m[1], m[0]);

    run4(16'h9999, 16'h0001, 1'b0, 1'b0, "R8 add ripple");
    run4(16'h9999, 16'h0000, 1'b0, 1'b1, "R5,R8 cin ripple");
    run4(16'h0000, 16'h0001, 1'b1, 1'b1, "R8 sub ripple");
    run4(16'h9999, 16'h9999, 1'b0, 1'b1, "R2 max add");
    run4(16'h4321, 16'h4321, 1'b1, 1'b0, "R9,R6 self sub");
    run4(16'h1000, 16'h0999, 1'b1, 1'b1, "R3,R4 borrow chain");

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ra, rb;
      for (int k = 0; k < 4; k++) begin
        ra[4*k +: 4] = 4'($urandom % 10);
        rb[4*k +: 4] = 4'($urandom % 10);
      end
      run4(ra, rb, n[0], n[1], n[0] ? "R3,R4,R6 random sub" : "R1,R2 random add");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule